// File: doc/BRIEF.md
# Delay-Slot Result Scheduler

This block models when results appear in the execute stage of a wide-issue core. Each accepted instruction carries a class, a destination register, a functional-unit index and its result value. The block holds the value until the class's delay-slot count has passed, then presents it on a register-write port. A separate countdown per functional unit tracks how long the unit stays occupied. An instruction sent to an occupied unit is refused and a structural-hazard flag is raised. Branches produce a delayed strobe instead of a register write. The arithmetic itself is not modelled; the result value arrives with the issue.

Each class with a register result has its own write lane, so writes maturing in the same cycle never block one another. When two lanes mature for the same destination register in one cycle, only the most recently issued one is written. Timing convention: an instruction accepted at clock edge k with D delay slots drives its lane's write strobe during the cycle after edge k+D+1. All outputs are registered.

Top module: `dsr_sched`

## Requirements
- R1: A synchronous active-high reset drops every pending write, pending branch and unit countdown. In the cycle after a reset edge, `wb_en`, `unit_busy`, `struct_hazard` and `branch_go` are all zero, and nothing issued before the reset is delivered later.
- R2: Class code 0 (single-cycle operation, zero delay slots) writes on lane 0. The strobe is high for one cycle after edge k+1. Lane i uses `wb_dst[i*AW +: AW]` and `wb_val[i*DW +: DW]`.
- R3: Class code 1 (multiply, one delay slot) writes on lane 1 for one cycle after edge k+2.
- R4: Class code 2 (load, four delay slots) writes on lane 2 for one cycle after edge k+5.
- R5: Class code 3 (double-precision multiply, nine delay slots) writes on lane 3 for one cycle after edge k+10.
- R6: Class code 4 (branch, five delay slots) raises `branch_go` for one cycle after edge k+6 and writes no register.
- R7: Class code 5 (store) and the unused codes 6 and 7 are accepted, occupy their unit for one cycle, and cause no register write and no branch strobe.
- R8: A class-3 instruction keeps its unit occupied for four issue slots. An issue to that unit at edges k+1 to k+3 is refused, and one at edge k+4 is accepted. Every other class frees its unit for the next edge. `unit_busy[u]` is high exactly in the cycles in which an issue to unit u would be refused.
- R9: An issue presented while its unit is occupied is dropped. `struct_hazard` is high in the following cycle, and the dropped instruction produces no write, no branch strobe and no occupancy.
- R10: If several lanes mature with the same destination register in one cycle, only the one with the fewest delay slots (the latest issued) strobes. Lanes with distinct destinations all strobe together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue request this cycle |
| iss_cls | input | 3 | Instruction class code |
| iss_dst | input | AW | Destination register index |
| iss_unit | input | $clog2(NU) | Functional-unit index |
| iss_data | input | DW | Result value to be delivered |
| wb_en | output | 4 | Per-lane register-write strobe |
| wb_dst | output | 4*AW | Per-lane destination register |
| wb_val | output | 4*DW | Per-lane write data |
| unit_busy | output | NU | Unit occupied; an issue to it is refused |
| struct_hazard | output | 1 | Previous cycle's issue was refused |
| branch_go | output | 1 | Branch takes effect |

## Verification
The assertions assume `iss_unit` is below NU, that there is at most one issue per cycle, and that the delay parameters rise strictly from lane 0 to lane 3, so that delay order matches issue order. The stimulus drives only units 0 to 3 of 8 and always uses the default delays. It draws destinations from a small set so that same-register collisions across lanes happen often. It mixes all eight class codes, so that double-precision multiplies regularly collide with later issues to the same unit.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_MUL  = 3'd1,
    CLS_LOAD = 3'd2,
    CLS_DMUL = 3'd3,
    CLS_BR   = 3'd4,
    CLS_ST   = 3'd5
  } dsr_cls_e;

  // one write lane per class with a register result; codes 0..3 map to lanes 0..3
  localparam int NLANE = 4;
endpackage

// File: rtl/dsr_lane.sv
module dsr_lane #(
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int DLY = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] in_dst,
  input  logic [DW-1:0] in_val,
  output logic          out_vld,
  output logic [AW-1:0] out_dst,
  output logic [DW-1:0] out_val
);
  localparam int N = DLY + 1;

  logic [N-1:0]  v;
  logic [AW-1:0] a [N];
  logic [DW-1:0] d [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
    end else begin
      v[0] <= in_vld;
      for (int k = 1; k < N; k++) v[k] <= v[k-1];
    end
  end

  always_ff @(posedge clk) begin
    a[0] <= in_dst;
    d[0] <= in_val;
    for (int k = 1; k < N; k++) begin
      a[k] <= a[k-1];
      d[k] <= d[k-1];
    end
  end

  assign out_vld = v[N-1];
  assign out_dst = a[N-1];
  assign out_val = d[N-1];
endmodule

// File: rtl/dsr_units.sv
module dsr_units #(
  parameter int NU       = 8,
  parameter int UW       = 3,
  parameter int OCC_LONG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [UW-1:0] unit,
  input  logic          long_occ,
  output logic          accept,
  output logic [NU-1:0] busy,
  output logic          hazard
);
  localparam int CW = $clog2(OCC_LONG) + 1;

  logic [CW-1:0] cnt [NU];

  assign accept = req && (cnt[unit] == '0);

  always_ff @(posedge clk) begin
    for (int u = 0; u < NU; u++) begin
      if (rst)
        cnt[u] <= '0;
      else if (accept && unit == UW'(u))
        cnt[u] <= long_occ ? CW'(OCC_LONG - 1) : '0;
      else if (cnt[u] != '0)
        cnt[u] <= cnt[u] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hazard <= 1'b0;
    else     hazard <= req && !accept;
  end

  for (genvar g = 0; g < NU; g++) begin : g_busy
    assign busy[g] = |cnt[g];
  end

  // R8
  long_occupy_chk: assert property (@(posedge clk) disable iff (rst)
    accept && long_occ |=> busy[$past(unit)]);

  // R8
  short_free_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !long_occ |=> !busy[$past(unit)]);

  // R9
  hazard_src_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |-> $past(req));
endmodule

// File: rtl/dsr_merge.sv
module dsr_merge #(
  parameter int NL = 4,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NL-1:0]    m_vld,
  input  logic [AW-1:0]    m_dst [NL],
  input  logic [DW-1:0]    m_val [NL],
  output logic [NL-1:0]    wb_en,
  output logic [NL*AW-1:0] wb_dst,
  output logic [NL*DW-1:0] wb_val
);
  logic [NL-1:0] keep;

  // lanes are ordered by rising delay, so a lower lane holds the later issue
  always_comb begin
    for (int i = 0; i < NL; i++) begin
      keep[i] = m_vld[i];
      for (int j = 0; j < i; j++)
        if (m_vld[j] && m_dst[j] == m_dst[i]) keep[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wb_en <= '0;
    else     wb_en <= keep;
    for (int i = 0; i < NL; i++) begin
      wb_dst[i*AW +: AW] <= m_dst[i];
      wb_val[i*DW +: DW] <= m_val[i];
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_pi
    for (genvar j = i + 1; j < NL; j++) begin : g_pj
      // R10
      lane_dst_unique_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en[i] && wb_en[j] |-> wb_dst[i*AW +: AW] != wb_dst[j*AW +: AW]);
    end
  end
endmodule

// File: rtl/dsr_sched.sv
module dsr_sched
  import dsr_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter int NU       = 8,
  parameter int DLY_MUL  = 1,
  parameter int DLY_LOAD = 4,
  parameter int DLY_DMUL = 9,
  parameter int DLY_BR   = 5,
  parameter int DMUL_OCC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iss_vld,
  input  logic [2:0]              iss_cls,
  input  logic [AW-1:0]           iss_dst,
  input  logic [$clog2(NU)-1:0]   iss_unit,
  input  logic [DW-1:0]           iss_data,
  output logic [NLANE-1:0]        wb_en,
  output logic [NLANE*AW-1:0]     wb_dst,
  output logic [NLANE*DW-1:0]     wb_val,
  output logic [NU-1:0]           unit_busy,
  output logic                    struct_hazard,
  output logic                    branch_go
);
  localparam int UW = $clog2(NU);
  localparam int LDLY [NLANE] = '{0, DLY_MUL, DLY_LOAD, DLY_DMUL};

  logic accept;

  dsr_units #(.NU(NU), .UW(UW), .OCC_LONG(DMUL_OCC)) u_units (
    .clk      (clk),
    .rst      (rst),
    .req      (iss_vld),
    .unit     (iss_unit),
    .long_occ (iss_cls == CLS_DMUL),
    .accept   (accept),
    .busy     (unit_busy),
    .hazard   (struct_hazard)
  );

  logic [NLANE-1:0] m_vld;
  logic [AW-1:0]    m_dst [NLANE];
  logic [DW-1:0]    m_val [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dsr_lane #(.AW(AW), .DW(DW), .DLY(LDLY[g])) u_lane (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (accept && iss_cls == 3'(g)),
      .in_dst  (iss_dst),
      .in_val  (iss_data),
      .out_vld (m_vld[g]),
      .out_dst (m_dst[g]),
      .out_val (m_val[g])
    );
  end

  dsr_merge #(.NL(NLANE), .AW(AW), .DW(DW)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .m_vld  (m_vld),
    .m_dst  (m_dst),
    .m_val  (m_val),
    .wb_en  (wb_en),
    .wb_dst (wb_dst),
    .wb_val (wb_val)
  );

  // branch strobe: one stage per delay slot plus the output stage
  logic [DLY_BR+1:0] br_pipe;

  always_ff @(posedge clk) begin
    if (rst) br_pipe <= '0;
    else     br_pipe <= {br_pipe[DLY_BR:0], accept && iss_cls == CLS_BR};
  end

  assign branch_go = br_pipe[DLY_BR+1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (wb_en == '0 && unit_busy == '0 && !struct_hazard && !branch_go));
endmodule

// File: tb/tb_dsr_sched.sv
`timescale 1ns/1ps
module tb_dsr_sched;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NU = 8;
  localparam int NL = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          iss_vld;
  logic [2:0]    iss_cls;
  logic [AW-1:0] iss_dst;
  logic [2:0]    iss_unit;
  logic [DW-1:0] iss_data;
  logic [NL-1:0]    wb_en;
  logic [NL*AW-1:0] wb_dst;
  logic [NL*DW-1:0] wb_val;
  logic [NU-1:0]    unit_busy;
  logic             struct_hazard;
  logic             branch_go;

  dsr_sched dut (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_dst(iss_dst),
    .iss_unit(iss_unit), .iss_data(iss_data), .wb_en(wb_en), .wb_dst(wb_dst),
    .wb_val(wb_val), .unit_busy(unit_busy), .struct_hazard(struct_hazard),
    .branch_go(branch_go)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int edge_n = 0;
  int free_at [NU];
  int p_due [64];
  int p_lane [64];
  logic [AW-1:0] p_dst [64];
  logic [DW-1:0] p_val [64];
  bit p_use [64];
  int br_due [16];
  bit br_use [16];
  int lane_dly [NL] = '{0, 1, 4, 9};
  string lane_tag [NL] = '{"R2", "R3", "R4", "R5"};
  int wr_seen = 0;
  int haz_seen = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at edge %0d", req, what, act, exp, edge_n);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) p_use[i] = 0;
    for (int i = 0; i < 16; i++) br_use[i] = 0;
    for (int u = 0; u < NU; u++) free_at[u] = 0;
  endtask

  task automatic step(bit r, bit v, int cls, int dst, int unit, logic [DW-1:0] val);
    int n;
    bit exp_haz;
    bit exp_en [NL];
    logic [AW-1:0] exp_dst [NL];
    logic [DW-1:0] exp_val [NL];
    bit sup [NL];
    bit exp_br;
    rst = r; iss_vld = v; iss_cls = 3'(cls); iss_dst = AW'(dst);
    iss_unit = 3'(unit); iss_data = val;
    n = edge_n + 1;
    exp_haz = 0;
    if (r) model_clear();
    else if (v) begin
      if (n >= free_at[unit]) begin
        free_at[unit] = n + ((cls == 3) ? 4 : 1);
        if (cls <= 3) begin
          for (int i = 0; i < 64; i++) if (!p_use[i]) begin
            p_use[i] = 1; p_due[i] = n + lane_dly[cls] + 1; p_lane[i] = cls;
            p_dst[i] = AW'(dst); p_val[i] = val;
            break;
          end
        end else if (cls == 4) begin
          for (int i = 0; i < 16; i++) if (!br_use[i]) begin
            br_use[i] = 1; br_due[i] = n + 6;
            break;
          end
        end
      end else exp_haz = 1;
    end
    @(posedge clk);
    edge_n = n;
    #2;
    for (int l = 0; l < NL; l++) begin
      exp_en[l] = 0; exp_dst[l] = '0; exp_val[l] = '0; sup[l] = 0;
    end
    for (int i = 0; i < 64; i++) if (p_use[i] && p_due[i] == n) begin
      exp_en[p_lane[i]] = 1; exp_dst[p_lane[i]] = p_dst[i]; exp_val[p_lane[i]] = p_val[i];
      p_use[i] = 0;
    end
    // later issue (shorter delay) wins on a shared destination
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < l; k++)
        if (exp_en[k] && exp_en[l] && exp_dst[k] == exp_dst[l]) begin
          exp_en[l] = 0; sup[l] = 1; sup[k] = 1;
        end
    exp_br = 0;
    for (int i = 0; i < 16; i++) if (br_use[i] && br_due[i] == n) begin
      exp_br = 1; br_use[i] = 0;
    end
    for (int l = 0; l < NL; l++) begin
      string tg;
      tg = r ? "R1" : (sup[l] ? "R10" : lane_tag[l]);
      chk(tg, $sformatf("wb_en[%0d]", l), 64'(wb_en[l]), 64'(exp_en[l]));
      if (exp_en[l] && wb_en[l]) begin
        chk(tg, $sformatf("wb_dst[%0d]", l), 64'(wb_dst[l*AW +: AW]), 64'(exp_dst[l]));
        chk(tg, $sformatf("wb_val[%0d]", l), 64'(wb_val[l*DW +: DW]), 64'(exp_val[l]));
      end
    end
    for (int u = 0; u < NU; u++)
      chk(r ? "R1" : "R8", $sformatf("unit_busy[%0d]", u), 64'(unit_busy[u]),
          64'(free_at[u] > n + 1));
    chk(r ? "R1" : "R9", "struct_hazard", 64'(struct_hazard), 64'(exp_haz));
    chk(r ? "R1" : "R6", "branch_go", 64'(branch_go), 64'(exp_br));
    if (|wb_en) wr_seen++;
    if (struct_hazard) haz_seen++;
    @(negedge clk);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_clear();
    rst = 1; iss_vld = 0; iss_cls = 0; iss_dst = 0; iss_unit = 0; iss_data = 0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, '0);
    // R2..R5: each class alone
    step(0, 1, 0, 3, 0, 32'hA0A0_0001); idle(3);
    step(0, 1, 1, 4, 1, 32'hB1B1_0002); idle(4);
    step(0, 1, 2, 5, 2, 32'hC2C2_0003); idle(7);
    step(0, 1, 3, 6, 3, 32'hD3D3_0004); idle(12);
    // R6: branch
    step(0, 1, 4, 0, 0, '0); idle(8);
    // R7: store and unused codes write nothing
    wr_seen = 0;
    step(0, 1, 5, 9, 0, 32'h1111); step(0, 1, 6, 10, 1, 32'h2222);
    step(0, 1, 7, 11, 2, 32'h3333); idle(12);
    chk("R7", "writes after store/unused codes", 64'(wr_seen), 64'd0);
    // R8/R9: double multiply holds its unit; three refused, fourth accepted
    haz_seen = 0;
    step(0, 1, 3, 12, 2, 32'h55);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 13, 2, 32'h60 + 32'(i));
    idle(12);
    chk("R9", "refused issues", 64'(haz_seen), 64'd3);
    // R10: load, multiply and single-cycle op mature together on register 7
    step(0, 1, 2, 7, 0, 32'h701); idle(2);
    step(0, 1, 1, 7, 1, 32'h702);
    step(0, 1, 0, 7, 2, 32'h703); idle(8);
    // R10: same cycle, distinct registers all delivered
    step(0, 1, 2, 8, 0, 32'h801); idle(2);
    step(0, 1, 1, 9, 1, 32'h802);
    step(0, 1, 0, 10, 2, 32'h803); idle(8);
    // R1: reset in flight drops pending results and occupancy
    step(0, 1, 2, 14, 0, 32'hE1); step(0, 1, 3, 15, 1, 32'hE2);
    step(0, 1, 4, 0, 2, '0);
    step(1, 0, 0, 0, 0, '0);
    wr_seen = 0;
    idle(14);
    chk("R1", "writes after reset in flight", 64'(wr_seen), 64'd0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r_v;
      r_v = ($urandom % 4) != 0;
      step(0, r_v, int'($urandom % 8), int'($urandom % 4), int'($urandom % 4), $urandom);
    end
    idle(14);
    finish_run();
  end
endmodule